// File: doc/BRIEF.md
# Relative Branch Target Unit

This block works out where execution goes after a control-transfer operation. Each request carries four things: the offset of the instruction that follows in sequence, a three-bit operation class, a signed 8-bit short displacement or a 16-bit absolute target, and the current zero, negative and carry flags. For each request the block returns the new instruction pointer, a flag that says whether the transfer was taken, and the 20-bit physical fetch address. The fetch address is the code segment value scaled by sixteen plus the new pointer.

The three conditional forms reach only a short window around the following instruction. The absolute jump and the call can reach any offset in the 64 KiB code segment. A call writes the return pointer to an external stack port and waits for that port to acknowledge. A return asks the same port for a word and adopts the word it gets back. While a call or return waits on the stack port, the block is busy and ignores new requests.

Top module: `brtgt_unit`

## Requirements
- R1: After a synchronous active-high reset, `res_valid`, `res_taken`, `res_ip`, `res_fetch`, `stk_push_req`, `stk_pop_req` and `busy` are all zero.
- R2: Class 0 (branch on zero) is taken when `flag_z` is 1. The target is `seq_ip` plus the displacement sign-extended to 16 bits, modulo 2^16. The result appears with `res_valid` one cycle after the request is accepted.
- R3: Class 1 (branch on less) is taken when `flag_n` is 1, with the same target rule and timing as R2.
- R4: Class 2 (branch on carry) is taken when `flag_c` is 1, with the same target rule and timing as R2.
- R5: A conditional class that is not taken returns `res_ip` equal to `seq_ip` and `res_taken` equal to 0.
- R6: Class 3 (absolute jump) always returns `res_taken`=1 and `res_ip`=`abs_ip`, whatever the flags are, one cycle after acceptance.
- R7: For class 4 (call), `stk_push_req` rises one cycle after acceptance, with `stk_push_ip` equal to `seq_ip`. Both stay unchanged until a cycle in which `stk_ack` is 1. One cycle after that ack, `res_valid` pulses with `res_ip`=`abs_ip` and `res_taken`=1.
- R8: For class 5 (return), `stk_pop_req` rises one cycle after acceptance and stays high until `stk_ack` is 1. One cycle after that ack, `res_valid` pulses with `res_ip` equal to the value of `stk_pop_ip` in the ack cycle, and with `res_taken`=1.
- R9: `res_fetch` equals (`code_seg` * 16 + `res_ip`) modulo 2^20. It uses the `code_seg` value captured when the request was accepted, and it is valid whenever `res_valid` is 1.
- R10: Classes 6 and 7 are reserved. They return `res_taken`=0 and `res_ip`=`seq_ip`.
- R11: While `busy` is 1, `req_valid` is ignored. No extra result is produced, and the pending push word does not change.
- R12: `res_valid` is a single-cycle pulse, one per accepted request, and it is never 1 while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| op_class | input | 3 | Operation class (0 zero, 1 less, 2 carry, 3 jump, 4 call, 5 return, 6-7 reserved) |
| seq_ip | input | 16 | Offset of the following instruction |
| disp | input | 8 | Signed short displacement |
| abs_ip | input | 16 | Absolute target offset |
| code_seg | input | 16 | Code segment value |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_c | input | 1 | Carry flag |
| stk_push_req | output | 1 | Push request to the stack port |
| stk_push_ip | output | 16 | Return pointer to push |
| stk_pop_req | output | 1 | Pop request to the stack port |
| stk_pop_ip | input | 16 | Popped word, sampled in the ack cycle |
| stk_ack | input | 1 | Stack port acknowledge |
| busy | output | 1 | Waiting on the stack port |
| res_valid | output | 1 | Result pulse |
| res_ip | output | 16 | New instruction pointer |
| res_taken | output | 1 | Transfer taken |
| res_fetch | output | 20 | Physical fetch address |

## Verification
A bad sign extension or a wrong flag selection shows up in `res_ip` or `res_taken` in the very next cycle after acceptance, so the bench sweeps every displacement against every flag combination. A sequencer that is stuck or leaves its state too early shows up at the stack port: the push word changes, a request drops before the ack, or a result pulse comes out while busy. All of these are visible within one cycle of the fault. A target held in the wrong register, or a segment captured at the wrong time, shows in `res_ip` or `res_fetch` in the cycle after the ack.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;
  typedef enum logic [2:0] {
    OP_BR_ZERO  = 3'd0,
    OP_BR_LESS  = 3'd1,
    OP_BR_CARRY = 3'd2,
    OP_JUMP     = 3'd3,
    OP_CALL     = 3'd4,
    OP_RETURN   = 3'd5,
    OP_RSV6     = 3'd6,
    OP_RSV7     = 3'd7
  } xfer_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PUSH = 2'd1,
    SQ_POP  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/brtgt_cond.sv
module brtgt_cond
  import brtgt_pkg::*;
(
  input  xfer_op_e op,
  input  logic     flag_z,
  input  logic     flag_n,
  input  logic     flag_c,
  output logic     take
);
  always_comb begin
    case (op)
      OP_BR_ZERO:  take = flag_z;
      OP_BR_LESS:  take = flag_n;
      OP_BR_CARRY: take = flag_c;
      OP_JUMP, OP_CALL, OP_RETURN: take = 1'b1;
      default:     take = 1'b0;
    endcase
  end
endmodule

// File: rtl/brtgt_target.sv
module brtgt_target
  import brtgt_pkg::*;
#(
  parameter int IP_W   = 16,
  parameter int DISP_W = 8
) (
  input  xfer_op_e          op,
  input  logic              take,
  input  logic [IP_W-1:0]   seq_ip,
  input  logic [DISP_W-1:0] disp,
  input  logic [IP_W-1:0]   abs_ip,
  output logic [IP_W-1:0]   target
);
  localparam int EXT_W = IP_W - DISP_W;

  logic [IP_W-1:0] disp_ext;
  logic [IP_W-1:0] rel_ip;

  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign rel_ip   = seq_ip + disp_ext;

  always_comb begin
    case (op)
      OP_BR_ZERO, OP_BR_LESS, OP_BR_CARRY: target = take ? rel_ip : seq_ip;
      OP_JUMP, OP_CALL:                    target = abs_ip;
      default:                             target = seq_ip;
    endcase
  end
endmodule

// File: rtl/brtgt_phys.sv
module brtgt_phys #(
  parameter int IP_W      = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic [IP_W-1:0]           seg,
  input  logic [IP_W-1:0]           off,
  output logic [IP_W+SEG_SHIFT-1:0] phys
);
  localparam int PA_W = IP_W + SEG_SHIFT;

  generate
    if (SEG_SHIFT == 0) begin : g_flat
      assign phys = seg + off;
    end else begin : g_scaled
      logic [PA_W-1:0] seg_scaled;
      logic [PA_W-1:0] off_wide;
      assign seg_scaled = {seg, {SEG_SHIFT{1'b0}}};
      assign off_wide   = {{SEG_SHIFT{1'b0}}, off};
      assign phys       = seg_scaled + off_wide;
    end
  endgenerate
endmodule

// File: rtl/brtgt_unit.sv
module brtgt_unit
  import brtgt_pkg::*;
#(
  parameter int IP_W      = 16,
  parameter int DISP_W    = 8,
  parameter int SEG_SHIFT = 4,
  localparam int PA_W     = IP_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        op_class,
  input  logic [IP_W-1:0]   seq_ip,
  input  logic [DISP_W-1:0] disp,
  input  logic [IP_W-1:0]   abs_ip,
  input  logic [IP_W-1:0]   code_seg,
  input  logic              flag_z,
  input  logic              flag_n,
  input  logic              flag_c,
  output logic              stk_push_req,
  output logic [IP_W-1:0]   stk_push_ip,
  output logic              stk_pop_req,
  input  logic [IP_W-1:0]   stk_pop_ip,
  input  logic              stk_ack,
  output logic              busy,
  output logic              res_valid,
  output logic [IP_W-1:0]   res_ip,
  output logic              res_taken,
  output logic [PA_W-1:0]   res_fetch
);
  seq_state_e      state;
  xfer_op_e        op;
  logic            take;
  logic [IP_W-1:0] tgt;
  logic [IP_W-1:0] pend_ip;
  logic [IP_W-1:0] seg_q;
  logic [IP_W-1:0] fin_ip;
  logic [IP_W-1:0] fin_seg;
  logic [PA_W-1:0] fin_phys;
  logic            accept;

  assign op     = xfer_op_e'(op_class);
  assign accept = req_valid && (state == SQ_IDLE);
  assign busy   = (state != SQ_IDLE);

  brtgt_cond u_cond (
    .op(op), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .take(take)
  );

  brtgt_target #(.IP_W(IP_W), .DISP_W(DISP_W)) u_target (
    .op(op), .take(take), .seq_ip(seq_ip), .disp(disp),
    .abs_ip(abs_ip), .target(tgt)
  );

  // Select the pointer and segment that will be registered as the result.
  always_comb begin
    case (state)
      SQ_PUSH: begin fin_ip = pend_ip;    fin_seg = seg_q;    end
      SQ_POP:  begin fin_ip = stk_pop_ip; fin_seg = seg_q;    end
      default: begin fin_ip = tgt;        fin_seg = code_seg; end
    endcase
  end

  brtgt_phys #(.IP_W(IP_W), .SEG_SHIFT(SEG_SHIFT)) u_phys (
    .seg(fin_seg), .off(fin_ip), .phys(fin_phys)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= SQ_IDLE;
      stk_push_req <= 1'b0;
      stk_push_ip  <= '0;
      stk_pop_req  <= 1'b0;
      pend_ip      <= '0;
      seg_q        <= '0;
      res_valid    <= 1'b0;
      res_ip       <= '0;
      res_taken    <= 1'b0;
      res_fetch    <= '0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (accept) begin
            seg_q <= code_seg;
            if (op == OP_CALL) begin
              state        <= SQ_PUSH;
              stk_push_req <= 1'b1;
              stk_push_ip  <= seq_ip;
              pend_ip      <= tgt;
            end else if (op == OP_RETURN) begin
              state       <= SQ_POP;
              stk_pop_req <= 1'b1;
            end else begin
              res_valid <= 1'b1;
              res_ip    <= fin_ip;
              res_taken <= take;
              res_fetch <= fin_phys;
            end
          end
        end
        SQ_PUSH: begin
          if (stk_ack) begin
            state        <= SQ_IDLE;
            stk_push_req <= 1'b0;
            res_valid    <= 1'b1;
            res_ip       <= fin_ip;
            res_taken    <= 1'b1;
            res_fetch    <= fin_phys;
          end
        end
        SQ_POP: begin
          if (stk_ack) begin
            state       <= SQ_IDLE;
            stk_pop_req <= 1'b0;
            res_valid   <= 1'b1;
            res_ip      <= fin_ip;
            res_taken   <= 1'b1;
            res_fetch   <= fin_phys;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assert_push_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (stk_push_req && !stk_ack) |=> (stk_push_req && $stable(stk_push_ip)));

  assert_pop_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (stk_pop_req && !stk_ack) |=> stk_pop_req);

  assert_one_stack_op_R11: assert property (@(posedge clk) disable iff (rst)
    !(stk_push_req && stk_pop_req));

  assert_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_valid_not_busy_R12: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !busy);

  assert_ack_ends_wait_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && stk_ack) |=> (res_valid && res_taken));
endmodule

// File: tb/brtgt_unit_bench.sv
module brtgt_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  op_class = '0;
  logic [15:0] seq_ip = '0;
  logic [7:0]  disp = '0;
  logic [15:0] abs_ip = '0;
  logic [15:0] code_seg = '0;
  logic        flag_z = 1'b0, flag_n = 1'b0, flag_c = 1'b0;
  logic        stk_push_req, stk_pop_req, busy, res_valid, res_taken;
  logic [15:0] stk_push_ip, res_ip;
  logic [15:0] stk_pop_ip = '0;
  logic        stk_ack = 1'b0;
  logic [19:0] res_fetch;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  brtgt_unit u_brtgt_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .op_class(op_class),
    .seq_ip(seq_ip), .disp(disp), .abs_ip(abs_ip), .code_seg(code_seg),
    .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c),
    .stk_push_req(stk_push_req), .stk_push_ip(stk_push_ip),
    .stk_pop_req(stk_pop_req), .stk_pop_ip(stk_pop_ip), .stk_ack(stk_ack),
    .busy(busy), .res_valid(res_valid), .res_ip(res_ip),
    .res_taken(res_taken), .res_fetch(res_fetch)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int fetch_of(int seg, int ip);
    return ((seg << 4) + ip) & 32'hFFFFF;
  endfunction

  task automatic do_xfer(int op, int ni, int d, int at, int seg, bit z, bit n, bit c);
    int  rel;
    bit  tk;
    int  exp_ip;
    string tag;
    @(negedge clk);
    chk("R12 idle between results", res_valid, 0);
    req_valid = 1; op_class = op[2:0]; seq_ip = ni[15:0]; disp = d[7:0];
    abs_ip = at[15:0]; code_seg = seg[15:0]; flag_z = z; flag_n = n; flag_c = c;
    @(negedge clk);
    req_valid = 0;
    rel = (ni + ((d >= 128) ? d - 256 : d)) & 32'hFFFF;
    case (op)
      0: begin tk = z; tag = "R2"; end
      1: begin tk = n; tag = "R3"; end
      2: begin tk = c; tag = "R4"; end
      3: begin tk = 1; tag = "R6"; end
      default: begin tk = 0; tag = "R10"; end
    endcase
    if (op == 3) exp_ip = at;
    else if (op <= 2 && tk) exp_ip = rel;
    else exp_ip = ni;
    if (!tk) tag = {tag, "/R5"};
    chk({tag, " valid"}, res_valid, 1);
    chk({tag, " ip"}, res_ip, exp_ip);
    chk({tag, " taken"}, res_taken, tk);
    chk("R9 fetch", res_fetch, fetch_of(seg, exp_ip));
  endtask

  task automatic do_stack(bit is_call, int ni, int at, int popv, int seg, int wait_cyc);
    @(negedge clk);
    req_valid = 1; op_class = is_call ? 3'd4 : 3'd5; seq_ip = ni[15:0];
    abs_ip = at[15:0]; code_seg = seg[15:0]; disp = 8'h80;
    @(negedge clk);
    // stray requests while busy must be ignored
    op_class = 3'd3; abs_ip = 16'hDEAD; seq_ip = 16'h0BAD; code_seg = 16'h7777;
    if (is_call) begin
      chk("R7 push req", stk_push_req, 1);
      chk("R7 push ip", stk_push_ip, ni);
    end else begin
      chk("R8 pop req", stk_pop_req, 1);
    end
    chk("R11 busy", busy, 1);
    for (int i = 0; i < wait_cyc; i++) begin
      @(negedge clk);
      chk("R11 no result while busy", res_valid, 0);
      if (is_call) begin
        chk("R7 push held", stk_push_req, 1);
        chk("R11 push ip unchanged", stk_push_ip, ni);
      end else begin
        chk("R8 pop held", stk_pop_req, 1);
      end
    end
    req_valid = 0;
    stk_ack = 1; stk_pop_ip = popv[15:0];
    @(negedge clk);
    stk_ack = 0; stk_pop_ip = 16'h5A5A;
    chk(is_call ? "R7 valid" : "R8 valid", res_valid, 1);
    chk(is_call ? "R7 ip" : "R8 ip", res_ip, is_call ? at : popv);
    chk(is_call ? "R7 taken" : "R8 taken", res_taken, 1);
    chk("R9 fetch held seg", res_fetch, fetch_of(seg, is_call ? at : popv));
    chk("R7 push dropped", stk_push_req, 0);
    chk("R8 pop dropped", stk_pop_req, 0);
    @(negedge clk);
    chk("R11 stray request dropped", res_valid, 0);
    chk("R12 not busy after", busy, 0);
  endtask

  initial begin
    #(4 * 190000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int ips[3] = '{16'h0005, 16'h7FF0, 16'hFFC0};
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 valid", res_valid, 0);
    chk("R1 ip", res_ip, 0);
    chk("R1 taken", res_taken, 0);
    chk("R1 fetch", res_fetch, 0);
    chk("R1 push", stk_push_req, 0);
    chk("R1 pop", stk_pop_req, 0);
    chk("R1 busy", busy, 0);

    for (int op = 0; op < 3; op++)
      for (int f = 0; f < 8; f++)
        for (int ii = 0; ii < 3; ii++)
          for (int d = 0; d < 256; d++)
            do_xfer(op, ips[ii], d, 16'h1111, (d * 257 + ii * 4099) & 16'hFFFF,
                    f[0], f[1], f[2]);

    for (int f = 0; f < 8; f++)
      for (int k = 0; k < 16; k++) begin
        do_xfer(3, k * 4001 & 16'hFFFF, k * 13 & 255, (k * 4369) & 16'hFFFF,
                16'hF000 + k, f[0], f[1], f[2]);
        do_xfer(6, k * 997 & 16'hFFFF, 8'h7F, 16'h2222, k * 3, f[0], f[1], f[2]);
        do_xfer(7, k * 555 & 16'hFFFF, 8'h01, 16'h3333, k * 5, f[0], f[1], f[2]);
      end

    for (int w = 0; w < 4; w++) begin
      do_stack(1, 16'h0103 + w, 16'hFFFF - w * 100, 0, 16'hFFFF - w, w);
      do_stack(0, 16'h0200 + w, 0, 16'hC000 + w * 77, 16'h1234 * (w + 1), w);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule